// File: doc/BRIEF.md
# DRAM Clock-Enable Power-Down Manager

This block drives the clock-enable line of each DRAM row pair behind a memory controller. A pair whose banks are all closed may be put into power-down to save standby current, which is done by dropping its clock-enable. An incoming access aimed at a sleeping pair brings it back. The block holds the access off with a ready signal until the pair has been awake long enough to accept commands.

At reset every clock-enable is low, and it stays low after reset until the controller mode field first takes a non-zero value. At that point all pairs wake together. Each pair also has a minimum time it must stay powered down once it enters, and a status bit shows whether it is currently powered down.

Top module: `dram_cke_pd_mgr`

## Requirements
- R1: While `pd_enable` is 0, no pair enters power-down. An armed pair whose clock-enable is high keeps it high. A powered-down pair wakes as soon as its minimum low time has passed, even without a request.
- R2: A pair enters power-down when all of the following hold on a clock edge: the block is armed, `pd_enable` is 1, every bank bit of that pair is 0, and no valid request targets the pair. Its `cke` bit goes low after that edge.
- R3: Pairs are independent. The banks of pair p are the bits `bank_open[p*BANKS_PER_PAIR +: BANKS_PER_PAIR]`, where 1 means open. One open bank keeps its own pair awake and has no effect on any other pair. A valid request with `req_pair` = p keeps pair p from entering.
- R4: A request to a powered-down pair sees `req_ready` low. When the pair's minimum low time has passed, its `cke` rises. `req_ready` goes high after `cke` has been high for `EXIT_CYC` cycles.
- R5: While `rst_n` is low, every `cke` bit, every `pd_status` bit and `req_ready` are 0. This applies immediately, without waiting for a clock edge.
- R6: After reset, `cke` stays all-zero until `ctrl_mode` is sampled non-zero on a clock edge. All `cke` bits then rise together after that edge. They stay armed if `ctrl_mode` later returns to 0, until the next reset.
- R7: Once a pair's `cke` falls, it stays low for at least `MIN_LOW_CYC` cycles, even if a request for that pair is waiting.
- R8: `pd_status[p]` is 1 exactly while armed pair p is powered down, that is, while its `cke` is low after arming.
- R9: `req_ready` is high in the same cycle whenever the pair selected by `req_pair` is armed and fully awake. It does not depend on `req_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pd_enable | input | 1 | Global enable for dynamic power-down |
| ctrl_mode | input | MODE_W | Controller mode field; non-zero arms the block |
| bank_open | input | NUM_PAIRS*BANKS_PER_PAIR | Per-bank open flags, grouped by pair |
| req_valid | input | 1 | Access request present |
| req_pair | input | PAIR_W | Row pair targeted by the request |
| req_ready | output | 1 | Targeted pair is awake and may be accessed |
| cke | output | NUM_PAIRS | Clock-enable per row pair |
| pd_status | output | NUM_PAIRS | Pair currently in power-down |

## Verification
The hardest case to reach is a request that lands on a pair while it is still inside its minimum low window. A related case is a pair that would go idle on the same edge that a request targets it. To reach both, the stimulus holds a request on one pair while all banks close, then moves the request to a pair that has just dropped its clock-enable. This exposes both the residency hold and the exit delay on `req_ready`. A second pair is left asleep while `pd_enable` is cleared, so that its wake-up without a request overlaps another pair's residency countdown.

// File: rtl/dram_pd_pkg.sv
package dram_pd_pkg;

  typedef enum logic [1:0] {
    PS_UP   = 2'd0,
    PS_DOWN = 2'd1,
    PS_WAKE = 2'd2
  } pd_state_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/dram_pd_arm.sv
module dram_pd_arm #(
  parameter int unsigned MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  output logic              armed_o
);

  logic armed_q;
  logic armed_d;
  logic armed_en;

  always_comb begin
    armed_en = ~armed_q;
    armed_d  = armed_q | (|mode_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (armed_en) begin
      armed_q <= armed_d;
    end
  end

  assign armed_o = armed_q;

  AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> armed_q); // R6
  AST_ARM_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(mode_i != '0)); // R6

endmodule

// File: rtl/dram_pd_pair_fsm.sv
module dram_pd_pair_fsm
  import dram_pd_pkg::*;
#(
  parameter int unsigned BANKS    = 4,
  parameter int unsigned MIN_LOW  = 4,
  parameter int unsigned EXIT_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed_i,
  input  logic             pd_en_i,
  input  logic [BANKS-1:0] bank_open_i,
  input  logic             hit_i,
  output logic             cke_o,
  output logic             pd_o,
  output logic             awake_o
);

  localparam int unsigned LOW_W  = $clog2(MIN_LOW + 1);
  localparam int unsigned EXIT_W = $clog2(EXIT_CYC + 1);

  pd_state_e          state_q, state_d;
  logic [LOW_W-1:0]   low_q, low_d;
  logic [EXIT_W-1:0]  exit_q, exit_d;
  logic               idle;
  logic               fsm_en;

  always_comb begin
    idle    = ~|bank_open_i;
    fsm_en  = armed_i;
    state_d = state_q;
    low_d   = low_q;
    exit_d  = exit_q;
    case (state_q)
      PS_UP: begin
        if (pd_en_i && idle && !hit_i) begin
          state_d = PS_DOWN;
          low_d   = LOW_W'(MIN_LOW - 1);
        end
      end
      PS_DOWN: begin
        if (low_q != '0) begin
          low_d = low_q - 1'b1;
        end
        if ((hit_i || !pd_en_i) && (low_q == '0)) begin
          state_d = PS_WAKE;
          exit_d  = EXIT_W'(EXIT_CYC - 1);
        end
      end
      PS_WAKE: begin
        if (exit_q == '0) begin
          state_d = PS_UP;
        end else begin
          exit_d = exit_q - 1'b1;
        end
      end
      default: begin
        state_d = PS_UP;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_UP;
      low_q   <= '0;
      exit_q  <= '0;
    end else if (fsm_en) begin
      state_q <= state_d;
      low_q   <= low_d;
      exit_q  <= exit_d;
    end
  end

  assign cke_o   = armed_i && (state_q != PS_DOWN);
  assign pd_o    = armed_i && (state_q == PS_DOWN);
  assign awake_o = armed_i && (state_q == PS_UP);

  // Independent residency tally for checking: cycles spent low since entry
  logic [LOW_W-1:0] chk_low;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_low <= '0;
    end else if (armed_i && !cke_o && chk_low < LOW_W'(MIN_LOW)) begin
      chk_low <= chk_low + 1'b1;
    end else if (armed_i && cke_o && !pd_en_i) begin
      chk_low <= '0;
    end else if (armed_i && $fell(cke_o)) begin
      chk_low <= chk_low;
    end else if (armed_i && cke_o && state_d == PS_DOWN) begin
      chk_low <= '0;
    end
  end

  AST_MIN_LOW_RESIDENCY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cke_o) && $past(armed_i)) |-> (chk_low >= LOW_W'(MIN_LOW))); // R7
  AST_ENTRY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_i && $fell(cke_o)) |-> $past(pd_en_i && idle && !hit_i)); // R2
  AST_NO_PD_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_i && cke_o && !pd_en_i) |=> cke_o); // R1

endmodule

// File: rtl/dram_pd_req_gate.sv
module dram_pd_req_gate #(
  parameter int unsigned NUM_PAIRS = 4,
  parameter int unsigned PAIR_W    = 2
) (
  input  logic                 req_valid_i,
  input  logic [PAIR_W-1:0]    req_pair_i,
  input  logic [NUM_PAIRS-1:0] awake_i,
  output logic [NUM_PAIRS-1:0] hit_o,
  output logic                 ready_o
);

  localparam int unsigned PAD_N = 1 << PAIR_W;

  logic [PAD_N-1:0] awake_pad;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_hit
    assign hit_o[p] = req_valid_i && (req_pair_i == PAIR_W'(p));
  end

  always_comb begin
    awake_pad                = '0;
    awake_pad[NUM_PAIRS-1:0] = awake_i;
    ready_o                  = awake_pad[req_pair_i];
  end

endmodule

// File: rtl/dram_cke_pd_mgr.sv
module dram_cke_pd_mgr
  import dram_pd_pkg::*;
#(
  parameter int unsigned NUM_PAIRS      = 4,
  parameter int unsigned BANKS_PER_PAIR = 4,
  parameter int unsigned MIN_LOW_CYC    = 4,
  parameter int unsigned EXIT_CYC       = 2,
  parameter int unsigned MODE_W         = 3,
  localparam int unsigned PAIR_W        = idx_width(NUM_PAIRS),
  localparam int unsigned BANK_BITS     = NUM_PAIRS * BANKS_PER_PAIR
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pd_enable,
  input  logic [MODE_W-1:0]    ctrl_mode,
  input  logic [BANK_BITS-1:0] bank_open,
  input  logic                 req_valid,
  input  logic [PAIR_W-1:0]    req_pair,
  output logic                 req_ready,
  output logic [NUM_PAIRS-1:0] cke,
  output logic [NUM_PAIRS-1:0] pd_status
);

  localparam int unsigned PAD_N = 1 << PAIR_W;

  logic                 armed;
  logic [NUM_PAIRS-1:0] hit;
  logic [NUM_PAIRS-1:0] awake;

  dram_pd_arm #(.MODE_W(MODE_W)) i_arm (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (ctrl_mode),
    .armed_o (armed)
  );

  dram_pd_req_gate #(.NUM_PAIRS(NUM_PAIRS), .PAIR_W(PAIR_W)) i_gate (
    .req_valid_i (req_valid),
    .req_pair_i  (req_pair),
    .awake_i     (awake),
    .hit_o       (hit),
    .ready_o     (req_ready)
  );

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    dram_pd_pair_fsm #(
      .BANKS    (BANKS_PER_PAIR),
      .MIN_LOW  (MIN_LOW_CYC),
      .EXIT_CYC (EXIT_CYC)
    ) i_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .armed_i     (armed),
      .pd_en_i     (pd_enable),
      .bank_open_i (bank_open[p*BANKS_PER_PAIR +: BANKS_PER_PAIR]),
      .hit_i       (hit[p]),
      .cke_o       (cke[p]),
      .pd_o        (pd_status[p]),
      .awake_o     (awake[p])
    );
  end

  logic [PAD_N-1:0] cke_pad;
  always_comb begin
    cke_pad                = '0;
    cke_pad[NUM_PAIRS-1:0] = cke;
  end

  AST_GRANT_NEEDS_CKE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> cke_pad[req_pair]); // R4
  AST_STATUS_NOT_WITH_CKE: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_status & cke) == '0); // R8

endmodule

// File: tb/test_dram_cke_pd_mgr.sv
`timescale 1ns/1ps
module test_dram_cke_pd_mgr;

  localparam int NP = 4;
  localparam int BP = 4;
  localparam real CLK_PER = 4.0;

  logic          clk;
  logic          rst_n;
  logic          pd_enable;
  logic [2:0]    ctrl_mode;
  logic [NP*BP-1:0] bank_open;
  logic          req_valid;
  logic [1:0]    req_pair;
  logic          req_ready;
  logic [NP-1:0] cke;
  logic [NP-1:0] pd_status;

  dram_cke_pd_mgr i_dram_cke_pd_mgr (
    .clk       (clk),
    .rst_n     (rst_n),
    .pd_enable (pd_enable),
    .ctrl_mode (ctrl_mode),
    .bank_open (bank_open),
    .req_valid (req_valid),
    .req_pair  (req_pair),
    .req_ready (req_ready),
    .cke       (cke),
    .pd_status (pd_status)
  );

  typedef struct {
    logic [NP-1:0] cke;
    logic [NP-1:0] st;
    logic          rdy;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 0;

  initial clk = 1'b0;
  always #(CLK_PER/2) clk = ~clk;

  // Driver side: record what the outputs must show in the current cycle
  task automatic cyc(input logic [NP-1:0] c, input logic [NP-1:0] s,
                     input logic r, input string t);
    exp_t e;
    e.cke = c; e.st = s; e.rdy = r; e.tag = t;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  // Monitor: compare just before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_tests++;
        if (cke !== e.cke || pd_status !== e.st || req_ready !== e.rdy) begin
          n_fail++;
          $display("FAIL %s: cke=%b exp %b, pd_status=%b exp %b, ready=%b exp %b",
                   e.tag, cke, e.cke, pd_status, e.st, req_ready, e.rdy);
        end
      end
    end
  end

  initial begin
    #(CLK_PER * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout exp finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    pd_enable = 1'b0;
    ctrl_mode = 3'b000;
    bank_open = '1;
    req_valid = 1'b1;
    req_pair  = 2'd0;
    @(negedge clk);

    // R5: reset holds everything low
    repeat (3) cyc(4'b0000, 4'b0000, 1'b0, "R5 reset");
    rst_n = 1'b1;
    // R6: still low while mode is zero
    repeat (3) cyc(4'b0000, 4'b0000, 1'b0, "R6 unarmed");
    ctrl_mode = 3'b111;
    cyc(4'b0000, 4'b0000, 1'b0, "R6 mode seen this edge");
    ctrl_mode = 3'b000;
    cyc(4'b1111, 4'b0000, 1'b1, "R6 all rise, R9 ready");
    bank_open = '0;
    req_valid = 1'b0;
    repeat (3) cyc(4'b1111, 4'b0000, 1'b1, "R1 disabled no entry");

    // pairs 1 and 2 each keep one bank open; request sits on pair 3
    pd_enable = 1'b1;
    bank_open = 16'h0210;
    req_valid = 1'b1;
    req_pair  = 2'd3;
    cyc(4'b1111, 4'b0000, 1'b1, "R2 pre-entry");
    req_pair  = 2'd0;
    cyc(4'b1110, 4'b0001, 1'b0, "R3 pair0 down, hit keeps pair3");
    cyc(4'b0110, 4'b1001, 1'b0, "R8 status pair0 and pair3");
    cyc(4'b0110, 4'b1001, 1'b0, "R7 residency hold");
    cyc(4'b0110, 4'b1001, 1'b0, "R7 residency hold");
    cyc(4'b0111, 4'b1000, 1'b0, "R4 cke up ready low");
    cyc(4'b0111, 4'b1000, 1'b0, "R4 exit wait");
    cyc(4'b0111, 4'b1000, 1'b1, "R4 ready after exit");
    req_valid = 1'b0;
    req_pair  = 2'd1;
    cyc(4'b0111, 4'b1000, 1'b1, "R9 ready ignores valid");
    pd_enable = 1'b0;
    cyc(4'b0110, 4'b1001, 1'b1, "R2 pair0 re-enters");
    cyc(4'b1110, 4'b0001, 1'b1, "R1 pair3 wakes on disable");
    cyc(4'b1110, 4'b0001, 1'b1, "R7 pair0 still held low");
    cyc(4'b1110, 4'b0001, 1'b1, "R7 pair0 still held low");
    cyc(4'b1111, 4'b0000, 1'b1, "R1 pair0 wakes after residency");
    repeat (3) cyc(4'b1111, 4'b0000, 1'b1, "R1 stays up");

    // R5 asynchronous reset mid-run, then R6 re-arm
    rst_n = 1'b0;
    cyc(4'b0000, 4'b0000, 1'b0, "R5 async reset");
    cyc(4'b0000, 4'b0000, 1'b0, "R5 reset held");
    rst_n = 1'b1;
    cyc(4'b0000, 4'b0000, 1'b0, "R6 needs new mode");
    cyc(4'b0000, 4'b0000, 1'b0, "R6 needs new mode");
    ctrl_mode = 3'b001;
    cyc(4'b0000, 4'b0000, 1'b0, "R6 mode seen this edge");
    ctrl_mode = 3'b000;
    cyc(4'b1111, 4'b0000, 1'b1, "R6 re-armed together");

    @(negedge clk);
    #2;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule